// File: doc/BRIEF.md
# DMA Controller Error Status Aggregator

This block keeps the sticky error state of a DMA channel controller and raises its error interrupt. It compares the occupancy of eight event queues against thresholds that software programs. It also keeps a running count of transfer completions that have been submitted but have not yet finished, and compares that count against a programmable allowed total. When either comparison trips, the matching error bit is latched. The bit stays set until software clears it.

Software sees a read-only status word and a separate write-one-to-clear register. It programs the thresholds and the completion limit through registers on a simple synchronous bus. Two summary inputs tell the block whether the event-miss registers elsewhere in the controller hold errors. The block emits a single-cycle interrupt pulse only when a new error appears while every error source, local or external, was clear.

The register map is as follows:

- Address 0 is the status word.
- Address 1 is the clear register.
- Address 2 holds the thresholds for queues 0 to 3.
- Address 3 holds the thresholds for queues 4 to 7.
- Address 4 holds the completion limit.

Top module: `dma_err_status_agg`

## Requirements
- R1: The status word at address 0 holds the threshold flag of queue i at bit i (bits 7:0) and the completion error flag at bit 16. All other bits read as 0. A read returns the state of the cycle in which the address was presented, one clock later on the read data port. Addresses 1, 5, 6 and 7 read as 0.
- R2: A queue flag sets in the cycle after that queue's 5-bit occupancy is strictly greater than its threshold. An occupancy equal to the threshold does not set it. The flag then stays at 1 whether or not the condition persists.
- R3: The outstanding count rises by one on a submit pulse and falls by one on a completion pulse. It is unchanged when both pulses arrive together. It saturates at 0 and at 63. The completion error flag sets in the cycle after the count is greater than or equal to the limit.
- R4: Writing 1 to bit n at address 1 clears status bit n. Writing 0 there has no effect, and writing address 0 changes nothing.
- R5: If a set condition and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: The interrupt output is a pulse one cycle long. It is asserted in the same cycle that a status bit first becomes visible, and only if, in the cycle before, the status word was 0 and both event-miss summary inputs were low.
- R7: After reset the status is 0, every threshold is 31, the limit is 63, the count is 0, and the interrupt and read data are 0.
- R8: Thresholds are written and read in byte lanes. Queue q uses bits [8*(q%4)+4 : 8*(q%4)] of address 2 + q/4. The limit uses bits 5:0 of address 4, and the unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| q_occupancy | input | 40 | Occupancy of each queue, 5 bits per queue, queue 0 in the low bits |
| xfer_submit | input | 1 | Pulse: one transfer completion is now outstanding |
| xfer_complete | input | 1 | Pulse: one outstanding completion has finished |
| evt_miss_pend | input | 1 | External event-miss register holds an error |
| qevt_miss_pend | input | 1 | External queued-event-miss register holds an error |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
The internal state is visible at the ports in a limited way. A latched flag that is wrong shows up on the very next status read. It also gates the interrupt, so it shows up as a missing or extra pulse the next time an error rises. A wrong outstanding count has no direct readout. It appears only when the count crosses the limit, which can be many cycles after the fault. For this reason the directed sequences drive the count to both saturation points and then move the limit, so that the completion error flag sets within one cycle of any mistake.

// File: rtl/dma_err_status_agg.sv
module dma_err_status_agg #(
  parameter int NQ     = 8,
  parameter int OCC_W  = 5,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NQ*OCC_W-1:0]   q_occupancy,
  input  logic                  xfer_submit,
  input  logic                  xfer_complete,
  input  logic                  evt_miss_pend,
  input  logic                  qevt_miss_pend,
  output logic                  err_irq
);

  localparam int TC_BIT = 16;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(1);
  localparam int                A_THR0 = 2;
  localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(A_THR0 + (NQ + 3) / 4);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [OCC_W-1:0] thr [NQ];
  logic [CNT_W-1:0] lim, outst;
  logic [NQ-1:0]    q_err, q_hit;
  logic             tc_err, tc_hit;
  logic [31:0]      status_w, rd_next;

  wire clr_wr = reg_we && (reg_addr == A_CLR);
  wire [NQ-1:0] q_clr = clr_wr ? reg_wdata[NQ-1:0] : '0;
  wire tc_clr = clr_wr && reg_wdata[TC_BIT];
  wire all_clear = (status_w == 32'd0) && !evt_miss_pend && !qevt_miss_pend;

  always_comb begin
    status_w = '0;
    status_w[NQ-1:0] = q_err;
    status_w[TC_BIT] = tc_err;
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_hit[q] = q_occupancy[q*OCC_W +: OCC_W] > thr[q];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        thr[q]   <= '1;
        q_err[q] <= 1'b0;
      end else begin
        if (reg_we && reg_addr == ADDR_W'(A_THR0 + q / 4))
          thr[q] <= reg_wdata[(q % 4) * 8 +: OCC_W];
        q_err[q] <= (q_err[q] && !q_clr[q]) || q_hit[q];
      end
    end

    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_err[q] && !q_clr[q] |=> q_err[q]);
    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      q_hit[q] |=> q_err[q]);
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      q_clr[q] && !q_hit[q] |=> !q_err[q]);
  end

  assign tc_hit = outst >= lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim     <= '1;
      outst   <= '0;
      tc_err  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_LIM) lim <= reg_wdata[CNT_W-1:0];
      if (xfer_submit && !xfer_complete && outst != CNT_MAX) outst <= outst + 1'b1;
      else if (xfer_complete && !xfer_submit && outst != '0) outst <= outst - 1'b1;
      tc_err  <= (tc_err && !tc_clr) || tc_hit;
      err_irq <= all_clear && (|q_hit || tc_hit);
    end
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == A_STAT) rd_next = status_w;
    else if (reg_addr == A_LIM) rd_next[CNT_W-1:0] = lim;
    for (int q = 0; q < NQ; q++)
      if (reg_addr == ADDR_W'(A_THR0 + q / 4))
        rd_next[(q % 4) * 8 +: OCC_W] = thr[q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
  assert_irq_needs_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(status_w == 32'd0 && !evt_miss_pend && !qevt_miss_pend));
  assert_irq_has_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> status_w != 32'd0);
  assert_count_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outst == CNT_MAX && xfer_submit && !xfer_complete |=> outst == CNT_MAX);
  assert_count_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outst == '0 && xfer_complete && !xfer_submit |=> outst == '0);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_addr) == A_STAT |-> reg_rdata[31:17] == '0 && reg_rdata[15:8] == '0);

endmodule

// File: tb/tb_dma_err_status_agg.sv
module tb_dma_err_status_agg;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [39:0] q_occupancy = 0;
  logic xfer_submit = 0, xfer_complete = 0, evt_miss_pend = 0, qevt_miss_pend = 0;
  logic err_irq;

  dma_err_status_agg dut (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  string sect = "R7 reset";

  logic [31:0] m_stat, m_rd;
  logic [4:0]  m_thr [8];
  logic [5:0]  m_lim, m_cnt;
  logic        m_irq;
  logic [2:0]  m_last_addr;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r = 0;
    case (a)
      3'd0: r = m_stat;
      3'd2: for (int q = 0; q < 4; q++) r[q*8 +: 5] = m_thr[q];
      3'd3: for (int q = 0; q < 4; q++) r[q*8 +: 5] = m_thr[q+4];
      3'd4: r[5:0] = m_lim;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", tag, sect, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic we, input logic [31:0] wd,
                     input logic [39:0] occ, input logic sub, input logic cmp,
                     input logic ev, input logic qev);
    logic [31:0] setv, clrm, nstat;
    logic [5:0] ncnt;
    @(negedge clk);
    chk("R6 irq", {31'd0, err_irq}, {31'd0, m_irq});
    chk((m_last_addr inside {3'd2, 3'd3, 3'd4}) ? "R8 rdata" : "R1 rdata", reg_rdata, m_rd);
    reg_addr = a; reg_we = we; reg_wdata = wd; q_occupancy = occ;
    xfer_submit = sub; xfer_complete = cmp; evt_miss_pend = ev; qevt_miss_pend = qev;
    setv = 0;
    for (int q = 0; q < 8; q++) setv[q] = occ[q*5 +: 5] > m_thr[q];
    setv[16] = m_cnt >= m_lim;
    clrm = (we && a == 3'd1) ? wd : 0;
    nstat = ((m_stat & ~clrm) | setv) & 32'h0001_00FF;
    m_irq = (m_stat == 0) && !ev && !qev && (setv != 0);
    m_rd = m_read(a);
    m_last_addr = a;
    ncnt = m_cnt;
    if (sub && !cmp && m_cnt != 6'd63) ncnt = m_cnt + 1;
    else if (cmp && !sub && m_cnt != 6'd0) ncnt = m_cnt - 1;
    m_cnt = ncnt;
    m_stat = nstat;
    if (we && a == 3'd2) for (int q = 0; q < 4; q++) m_thr[q] = wd[q*8 +: 5];
    if (we && a == 3'd3) for (int q = 0; q < 4; q++) m_thr[q+4] = wd[q*8 +: 5];
    if (we && a == 3'd4) m_lim = wd[5:0];
  endtask

  task automatic idle(input logic [2:0] a);
    cyc(a, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_stat = 0; m_rd = 0; m_lim = 6'd63; m_cnt = 0; m_irq = 0; m_last_addr = 0;
    for (int q = 0; q < 8; q++) m_thr[q] = 5'd31;
    repeat (3) @(negedge clk);
    rst_n = 1;

    sect = "R7 reset";
    idle(0); idle(2); idle(3); idle(4); idle(1); idle(0);

    sect = "R8 regs";
    cyc(2, 1, 32'hFFE3_0201, 0, 0, 0, 0, 0);
    cyc(3, 1, 32'h0706_0504, 0, 0, 0, 0, 0);
    cyc(4, 1, 32'hFFFF_FFC5, 0, 0, 0, 0, 0);
    idle(2); idle(3); idle(4); idle(5); idle(7);

    sect = "R2 threshold";
    cyc(0, 0, 0, 40'd3 << 10, 0, 0, 0, 0);
    idle(0);
    cyc(0, 0, 0, 40'd4 << 10, 0, 0, 0, 0);
    idle(0); idle(0);
    cyc(0, 0, 0, 40'd4 << 10, 0, 0, 0, 0);
    idle(0);

    sect = "R4 clear";
    cyc(1, 1, 32'h0, 0, 0, 0, 0, 0); idle(0);
    cyc(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); idle(0);
    cyc(1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); idle(0); idle(0);

    sect = "R6 gating";
    cyc(0, 0, 0, 40'd31 << 25, 0, 0, 1, 0); idle(0);
    cyc(1, 1, 32'h0001_00FF, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 40'd31 << 30, 0, 0, 0, 1); idle(0);
    cyc(1, 1, 32'h0001_00FF, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 40'd31 << 35, 0, 0, 0, 0);
    cyc(0, 0, 0, 40'd31, 0, 0, 0, 0); idle(0);

    sect = "R5 set wins";
    cyc(1, 1, 32'h0001_00FF, 40'd31 << 5, 0, 0, 0, 0); idle(0);
    cyc(1, 1, 32'h0001_00FF, 0, 0, 0, 0, 0); idle(0);

    sect = "R3 counter";
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
    idle(0); idle(0);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(1, 1, 32'h0001_0000, 0, 0, 0, 0, 0);
    cyc(4, 1, 32'd1, 0, 0, 0, 0, 0); idle(0); idle(0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(0); idle(0);
    cyc(4, 1, 32'd63, 0, 0, 0, 0, 0);
    cyc(1, 1, 32'h0001_0000, 0, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(1, 1, 32'h0001_0000, 0, 0, 0, 0, 0); idle(0);
    cyc(4, 1, 32'd62, 0, 0, 0, 0, 0); idle(0); idle(0);
    for (int i = 0; i < 70; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(1, 1, 32'h0001_00FF, 0, 0, 0, 0, 0); idle(0);

    sect = "R1 R6 random";
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic we;
      logic [31:0] wd;
      logic [39:0] occ;
      a = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 9) < 2);
      wd = $urandom;
      if (we && a == 3'd1 && $urandom_range(0, 3) != 0) wd = 32'h0001_00FF;
      occ = 0;
      for (int q = 0; q < 8; q++)
        occ[q*5 +: 5] = ($urandom_range(0, 15) == 0) ? 5'($urandom) : 5'($urandom_range(0, 8));
      cyc(a, we, wd, occ, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
          ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
    end
    idle(0); idle(0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule